// File: doc/BRIEF.md
# Inter-Processor Command and Wake-Up Sequencer

This block sends inter-processor interrupt commands to a 64-bit command register. It handles two kinds of request. A single INIT or SMI command goes either to one processor or to every processor except the sender. A wake-up request sends an INIT command, then two start-up commands, with fixed microsecond gaps between the three steps. The block builds each command word from the operation, the destination and the start-up page. It checks every request before it sends anything, and it reports a rejected request with a one-cycle error pulse.

The register access style is chosen per request with `ext_mode`. In the 32-bit style the block writes the high word first and the low word second. Writing the low word is what sends the command. The block then polls the delivery-status input until the fabric has taken the command. In the 64-bit style a single wide write sends the command, and the block does not poll. Gaps are counted in whole periods of a one-cycle `us_tick` strobe. A request is sampled only while the block is idle.

Top module: `ipi_seq`

## Requirements
- R1: In the 32-bit style each command is two consecutive strobes. The first has `cmd_sel`=01 and carries the destination ID in `cmd_data[31:24]`, with all other bits 0. The second has `cmd_sel`=00 and carries the low word in `cmd_data[31:0]`. `cmd_sel`=11 never occurs.
- R2: After a 32-bit-style low-word strobe, the step does not end while `dlv_pend` is 1. The step ends in the first following cycle in which `dlv_pend` is 0. `done` or the next gap follows in the cycle after that.
- R3: In the 64-bit style each command is one strobe with `cmd_sel`=10, the destination ID in `cmd_data[63:32]` and the low word in `cmd_data[31:0]`. `dlv_pend` is ignored, and the step ends in the strobe cycle itself.
- R4: A wake-up request (`req_op`=2) issues INIT, then start-up, then start-up again. Exactly `GAP_SHORT_US` (10) `us_tick` pulses fall between the end of the first step and the first strobe of the second step. Exactly `GAP_LONG_US` (200) fall between the end of the second step and the third step. Each next step begins in the cycle after the tick that completes its gap.
- R5: Low-word fields are as follows. The vector is in bits 7:0. The delivery mode is in bits 10:8: INIT=101, SMI=010, start-up=110. The delivery-status bit 12 is written as 0. The level bit 14 is 1. The shorthand is in bits 19:18. All other bits are 0. The start-up vector is `req_addr[19:12]`, and INIT and SMI use vector 0.
- R6: With `req_others`=1 the shorthand field is 11 and the destination ID sent is 0, whatever `req_target` holds. Otherwise the shorthand is 00.
- R7: A wake-up request whose address is 0x100000 or higher, or whose bits 11:0 are not zero, is rejected. A rejected request gives `err` high for the one cycle after the request, produces no strobe, and leaves `busy` low.
- R8: The block also rejects, in the same way as R7, a request with `req_op`=3. It rejects a 32-bit-style request to a single destination whose ID is above 255. In the 64-bit style any 32-bit ID is accepted.
- R9: `req_op`=0 (INIT) and `req_op`=1 (SMI) each send exactly one command and then finish.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the sequence ends. `done` is high for exactly one cycle, with `busy` already low. Requests that arrive while `busy` is high have no effect. Every strobe occurs while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | Register style for the request: 1 = single 64-bit write, 0 = two 32-bit writes with polling |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 = INIT, 1 = SMI, 2 = wake-up sequence, 3 = reserved (rejected) |
| req_others | input | 1 | Send to all processors except the sender |
| req_target | input | 32 | Destination processor ID |
| req_addr | input | AW (32) | Start-up code address for the wake-up sequence |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| dlv_pend | input | 1 | Delivery status from the fabric: 1 = command not yet accepted |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | One-cycle pulse for a rejected request |
| cmd_wr | output | 1 | Command register write strobe |
| cmd_sel | output | 2 | 00 = low word, 01 = high word, 10 = full 64-bit write |
| cmd_data | output | 64 | Write data; 32-bit writes use bits 31:0 |

## Verification
The properties assume that `dlv_pend` is a clean level from the fabric that eventually falls to 0. They also assume that `us_tick` is a single-cycle pulse. The bench models the fabric so that it raises delivery status only after a low-word write and holds it for a fixed three cycles. It spaces ticks four cycles apart. The bench changes requests only away from the clock edge, and during 64-bit-style runs it holds `dlv_pend` high to show that the status is ignored. Gap lengths are measured against tick counts that the bench keeps itself, starting from the step end it infers at the ports.

// File: rtl/ipi_seq_pkg.sv
package ipi_seq_pkg;

  typedef enum logic [1:0] {
    OP_INIT = 2'd0,
    OP_SMI  = 2'd1,
    OP_BOOT = 2'd2,
    OP_RSVD = 2'd3
  } ipi_op_e;

  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_WIDE = 2'b10
  } cmd_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_POLL,
    ST_WIDE,
    ST_GAP
  } seq_st_e;

  localparam logic [2:0] DM_SMI   = 3'b010;
  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;
  localparam logic [1:0] SH_NONE   = 2'b00;
  localparam logic [1:0] SH_OTHERS = 2'b11;
  localparam int LEVEL_BIT = 14;
  localparam logic [1:0] LAST_BOOT_STEP = 2'd2;

  // Low command word: vector, delivery mode, level, shorthand.
  function automatic logic [31:0] pack_low(input logic [2:0] dm,
                                           input logic [7:0] vec,
                                           input logic       others);
    logic [31:0] w;
    w            = '0;
    w[7:0]       = vec;
    w[10:8]      = dm;
    w[LEVEL_BIT] = 1'b1;
    w[19:18]     = others ? SH_OTHERS : SH_NONE;
    return w;
  endfunction

  // High word of the 32-bit style: eight-bit ID in the top byte.
  function automatic logic [31:0] pack_legacy_high(input logic [7:0] id);
    return {id, 24'h000000};
  endfunction

  function automatic logic [2:0] step_mode(input ipi_op_e op, input logic [1:0] step);
    logic [2:0] dm;
    case (op)
      OP_SMI:  dm = DM_SMI;
      OP_BOOT: dm = (step == 2'd0) ? DM_INIT : DM_START;
      default: dm = DM_INIT;
    endcase
    return dm;
  endfunction

  function automatic logic [7:0] step_vector(input ipi_op_e op, input logic [1:0] step,
                                             input logic [7:0] page);
    return (op == OP_BOOT && step != 2'd0) ? page : 8'h00;
  endfunction

endpackage

// File: rtl/ipi_req_check.sv
module ipi_req_check
  import ipi_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    op,
  input  logic          others,
  input  logic          ext,
  input  logic [31:8]   target_upper,
  input  logic [AW-1:20] addr_upper,
  input  logic [11:0]   addr_lower,
  output logic          ok
);
  logic op_ok, id_ok, addr_ok;

  always_comb begin
    op_ok   = (ipi_op_e'(op) != OP_RSVD);
    id_ok   = ext || others || (target_upper == '0);
    addr_ok = (ipi_op_e'(op) != OP_BOOT) ||
              ((addr_upper == '0) && (addr_lower == 12'h000));
    ok      = op_ok && id_ok && addr_ok;
  end
endmodule

// File: rtl/ipi_cmd_build.sv
module ipi_cmd_build
  import ipi_seq_pkg::*;
(
  input  ipi_op_e     op,
  input  logic [1:0]  step,
  input  logic        others,
  input  logic [31:0] target,
  input  logic [7:0]  page,
  output logic [31:0] lo_word,
  output logic [31:0] hi_legacy,
  output logic [31:0] hi_wide
);
  always_comb begin
    lo_word   = pack_low(step_mode(op, step), step_vector(op, step, page), others);
    hi_legacy = pack_legacy_high(target[7:0]);
    hi_wide   = target;
  end
endmodule

// File: rtl/ipi_gap_timer.sv
module ipi_gap_timer #(
  parameter int SHORT_LEN = 10,
  parameter int LONG_LEN  = 200,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic             long_sel,
  input  logic             us_tick,
  output logic             expire,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] SHORT_C = SHORT_LEN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] LONG_C  = LONG_LEN[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    len     = long_sel ? LONG_C : SHORT_C;
    cnt_inc = cnt_q + 1'b1;
    expire  = run && us_tick && (cnt_inc == len);
    cnt     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (arm || expire)    cnt_q <= '0;
    else if (run && us_tick)   cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/ipi_seq.sv
module ipi_seq
  import ipi_seq_pkg::*;
#(
  parameter int AW           = 32,
  parameter int GAP_SHORT_US = 10,
  parameter int GAP_LONG_US  = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_mode,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_others,
  input  logic [31:0]   req_target,
  input  logic [AW-1:0] req_addr,
  input  logic          us_tick,
  input  logic          dlv_pend,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          cmd_wr,
  output logic [1:0]    cmd_sel,
  output logic [63:0]   cmd_data
);
  localparam int MAX_GAP = (GAP_LONG_US > GAP_SHORT_US) ? GAP_LONG_US : GAP_SHORT_US;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  seq_st_e     state_q;
  ipi_op_e     op_q;
  logic        others_q, ext_q;
  logic [31:0] tgt_q;
  logic [7:0]  page_q;
  logic [1:0]  step_q;
  logic        done_q, err_q;

  logic        req_ok, accept;
  logic [31:0] lo_word, hi_legacy, hi_wide;
  logic        gap_expire;
  logic [CNT_W-1:0] gap_cnt, gap_len;

  // Named internal events used by the bound checker.
  logic in_poll, in_gap, step_end, last_step;

  ipi_req_check #(.AW(AW)) u_req_check (
    .op           (req_op),
    .others       (req_others),
    .ext          (ext_mode),
    .target_upper (req_target[31:8]),
    .addr_upper   (req_addr[AW-1:20]),
    .addr_lower   (req_addr[11:0]),
    .ok           (req_ok)
  );

  ipi_cmd_build u_cmd_build (
    .op        (op_q),
    .step      (step_q),
    .others    (others_q),
    .target    (tgt_q),
    .page      (page_q),
    .lo_word   (lo_word),
    .hi_legacy (hi_legacy),
    .hi_wide   (hi_wide)
  );

  ipi_gap_timer #(
    .SHORT_LEN (GAP_SHORT_US),
    .LONG_LEN  (GAP_LONG_US),
    .CNT_W     (CNT_W)
  ) u_gap_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (step_end),
    .run      (in_gap),
    .long_sel (step_q != 2'd0),
    .us_tick  (us_tick),
    .expire   (gap_expire),
    .cnt      (gap_cnt),
    .len      (gap_len)
  );

  always_comb begin
    accept    = req_valid && (state_q == ST_IDLE);
    in_poll   = (state_q == ST_POLL);
    in_gap    = (state_q == ST_GAP);
    step_end  = (in_poll && !dlv_pend) || (state_q == ST_WIDE);
    last_step = (op_q != OP_BOOT) || (step_q == LAST_BOOT_STEP);
  end

  always_comb begin
    cmd_wr   = 1'b0;
    cmd_sel  = SEL_LO;
    cmd_data = '0;
    case (state_q)
      ST_HI: begin
        cmd_wr   = 1'b1;
        cmd_sel  = SEL_HI;
        cmd_data = {32'h0, hi_legacy};
      end
      ST_LO: begin
        cmd_wr   = 1'b1;
        cmd_sel  = SEL_LO;
        cmd_data = {32'h0, lo_word};
      end
      ST_WIDE: begin
        cmd_wr   = 1'b1;
        cmd_sel  = SEL_WIDE;
        cmd_data = {hi_wide, lo_word};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_INIT;
      others_q <= 1'b0;
      ext_q    <= 1'b0;
      tgt_q    <= '0;
      page_q   <= '0;
      step_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_ok) begin
              op_q     <= ipi_op_e'(req_op);
              others_q <= req_others;
              ext_q    <= ext_mode;
              tgt_q    <= req_others ? 32'h0 : req_target;
              page_q   <= req_addr[19:12];
              step_q   <= 2'd0;
              state_q  <= ext_mode ? ST_WIDE : ST_HI;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_HI:  state_q <= ST_LO;
        ST_LO:  state_q <= ST_POLL;
        ST_POLL, ST_WIDE: begin
          if (step_end) begin
            if (last_step) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_expire) begin
            step_q  <= step_q + 2'd1;
            state_q <= ext_q ? ST_WIDE : ST_HI;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy = (state_q != ST_IDLE);
    done = done_q;
    err  = err_q;
  end
endmodule

// File: rtl/ipi_seq_chk.sv
module ipi_seq_chk
  import ipi_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic [1:0]       cmd_sel,
  input logic [63:0]      cmd_data,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             dlv_pend,
  input logic             in_poll,
  input logic [CNT_W-1:0] gap_cnt,
  input logic [CNT_W-1:0] gap_len
);
  AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> busy); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !cmd_wr)); // R10
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !cmd_wr)); // R7
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_sel == SEL_HI) |=> (cmd_wr && cmd_sel == SEL_LO)); // R1
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (cmd_sel != 2'b11)); // R1
  AST_POLL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_poll && dlv_pend) |=> (!done && !cmd_wr)); // R2
  AST_WIDE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_sel == SEL_WIDE) |=> !cmd_wr); // R3
  AST_LEVEL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_sel != SEL_HI) |-> cmd_data[LEVEL_BIT]); // R5
  AST_BCAST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_sel == SEL_WIDE && cmd_data[19:18] == SH_OTHERS) |-> (cmd_data[63:32] == 32'h0)); // R6
  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt < gap_len); // R4
endmodule

bind ipi_seq ipi_seq_chk #(.CNT_W(CNT_W)) u_seq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .cmd_sel  (cmd_sel),
  .cmd_data (cmd_data),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .dlv_pend (dlv_pend),
  .in_poll  (in_poll),
  .gap_cnt  (gap_cnt),
  .gap_len  (gap_len)
);

// File: tb/ipi_seq_tb.sv
`timescale 1ns/1ps
module ipi_seq_tb;
  localparam int PEND_CYC = 3;
  localparam int TICK_DIV = 4;
  localparam int SHORT_G  = 10;
  localparam int LONG_G   = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0, req_valid = 1'b0, req_others = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_target = '0, req_addr = '0;
  logic        us_tick = 1'b0, dlv_pend = 1'b0;
  logic        busy, done, err, cmd_wr;
  logic [1:0]  cmd_sel;
  logic [63:0] cmd_data;

  ipi_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
    .req_op(req_op), .req_others(req_others), .req_target(req_target),
    .req_addr(req_addr), .us_tick(us_tick), .dlv_pend(dlv_pend),
    .busy(busy), .done(done), .err(err), .cmd_wr(cmd_wr),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // Monitor state
  int          cyc = 0, n_wr = 0, n_done = 0, n_err = 0, done_cyc = 0, anchor_cyc = 0;
  int          ticks_since = 0, last_tick = -10;
  bit          busy_seen = 0, poll_wait = 0, lo_seen = 0, force_pend = 0;
  logic [1:0]  w_sel [0:15];
  logic [63:0] w_dat [0:15];
  int          w_gap [0:15];
  int          w_cyc [0:15];
  bit          w_pt  [0:15];

  // Fabric and tick model
  int pend_left = 0, tdiv = 0;
  always @(posedge clk) begin
    #3;
    if (lo_seen) begin
      lo_seen   = 0;
      pend_left = PEND_CYC;
    end else if (pend_left > 0) begin
      pend_left--;
    end
    dlv_pend = force_pend || (pend_left > 0);
    tdiv     = (tdiv + 1) % TICK_DIV;
    us_tick  = (tdiv == 0);
  end

  always @(negedge clk) begin
    bit anchor;
    cyc++;
    anchor = 0;
    if (busy) busy_seen = 1;
    if (done) begin n_done++; done_cyc = cyc; end
    if (err)  n_err++;
    if (poll_wait && !dlv_pend) begin anchor = 1; poll_wait = 0; end
    if (cmd_wr) begin
      if (n_wr < 16) begin
        w_sel[n_wr] = cmd_sel;
        w_dat[n_wr] = cmd_data;
        w_gap[n_wr] = ticks_since;
        w_cyc[n_wr] = cyc;
        w_pt[n_wr]  = (last_tick == cyc - 1);
      end
      n_wr++;
      if (cmd_sel == 2'b10) anchor = 1;
    end
    if (us_tick) begin ticks_since++; last_tick = cyc; end
    if (anchor) begin ticks_since = 0; anchor_cyc = cyc; end
    if (cmd_wr && cmd_sel == 2'b00) begin poll_wait = 1; lo_seen = 1; end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lo(input logic [2:0] dm, input logic [7:0] vec, input bit oth);
    logic [31:0] w = 32'h0;
    w[7:0]   = vec;
    w[10:8]  = dm;
    w[14]    = 1'b1;
    if (oth) w[19:18] = 2'b11;
    return w;
  endfunction

  task automatic clear_mon();
    @(negedge clk);
    n_wr = 0; n_done = 0; n_err = 0; busy_seen = 0;
  endtask

  task automatic send_req(input logic [1:0] op, input bit oth, input logic [31:0] tgt,
                          input logic [31:0] adr, input bit ext);
    @(posedge clk); #2;
    ext_mode = ext; req_op = op; req_others = oth; req_target = tgt; req_addr = adr;
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (n_done > 0 || n_err > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !err && !cmd_wr, "R10 reset outputs idle",
        {busy, done, err, cmd_wr}, 0);
  endtask

  // R9: single INIT or SMI
  task automatic t_single(input logic [1:0] op, input bit oth, input logic [31:0] tgt, input bit ext);
    logic [31:0] lo, tid;
    clear_mon();
    force_pend = ext;
    send_req(op, oth, tgt, 32'h0, ext);
    wait_end();
    force_pend = 0;
    lo  = exp_lo((op == 2'd1) ? 3'b010 : 3'b101, 8'h00, oth);
    tid = oth ? 32'h0 : tgt;
    if (!ext) begin
      chk(n_wr == 2, "R9 single command write count (32-bit style)", n_wr, 2);
      chk(w_sel[0] == 2'b01 && w_dat[0] == {32'h0, tid[7:0], 24'h0},
          "R1 high word first with ID in top byte", w_dat[0], {32'h0, tid[7:0], 24'h0});
      chk(w_sel[1] == 2'b00 && w_dat[1] == {32'h0, lo}, "R5 low word fields",
          w_dat[1], {32'h0, lo});
      chk(done_cyc - w_cyc[1] == PEND_CYC + 2, "R2 done waits for delivery status",
          done_cyc - w_cyc[1], PEND_CYC + 2);
    end else begin
      chk(n_wr == 1, "R9 single command write count (64-bit style)", n_wr, 1);
      chk(w_sel[0] == 2'b10 && w_dat[0] == {tid, lo}, "R3 wide write data",
          w_dat[0], {tid, lo});
      chk(done_cyc == w_cyc[0] + 1, "R3 no polling in 64-bit style",
          done_cyc - w_cyc[0], 1);
    end
    if (oth) chk(w_dat[n_wr-1][19:18] == 2'b11, "R6 shorthand set for broadcast",
                 w_dat[n_wr-1][19:18], 2'b11);
    chk(n_done == 1 && busy_seen && n_err == 0, "R10 one done pulse and busy seen",
        {n_done[7:0], 7'h0, busy_seen}, {8'd1, 8'd1});
  endtask

  task automatic check_boot_words(input bit oth, input logic [31:0] tgt,
                                  input logic [31:0] adr, input bit ext);
    int per;
    logic [31:0] tid;
    per = ext ? 1 : 2;
    tid = oth ? 32'h0 : tgt;
    chk(n_wr == 3 * per, "R4 wake-up sequence write count", n_wr, 3 * per);
    for (int s = 0; s < 3; s++) begin
      int b;
      logic [31:0] lo;
      b  = s * per;
      lo = exp_lo((s == 0) ? 3'b101 : 3'b110, (s == 0) ? 8'h00 : adr[19:12], oth);
      if (ext) begin
        chk(w_sel[b] == 2'b10 && w_dat[b] == {tid, lo}, "R5 wake-up wide command word",
            w_dat[b], {tid, lo});
      end else begin
        chk(w_sel[b] == 2'b01 && w_dat[b] == {32'h0, tid[7:0], 24'h0},
            "R1 wake-up high word", w_dat[b], {32'h0, tid[7:0], 24'h0});
        chk(w_sel[b+1] == 2'b00 && w_dat[b+1] == {32'h0, lo}, "R5 wake-up low word",
            w_dat[b+1], {32'h0, lo});
      end
      if (s > 0) begin
        chk(w_gap[b] == ((s == 1) ? SHORT_G : LONG_G), "R4 gap tick count",
            w_gap[b], (s == 1) ? SHORT_G : LONG_G);
        chk(w_pt[b], "R4 step starts right after completing tick", w_pt[b], 1);
      end
    end
  endtask

  task automatic t_boot(input bit oth, input logic [31:0] tgt, input logic [31:0] adr, input bit ext);
    clear_mon();
    force_pend = ext;
    send_req(2'd2, oth, tgt, adr, ext);
    wait_end();
    force_pend = 0;
    check_boot_words(oth, tgt, adr, ext);
    chk(done_cyc == anchor_cyc + 1, "R2 done follows final step end",
        done_cyc - anchor_cyc, 1);
    chk(n_done == 1 && n_err == 0, "R10 single done for wake-up", n_done, 1);
  endtask

  task automatic t_reject(input logic [1:0] op, input bit oth, input logic [31:0] tgt,
                          input logic [31:0] adr, input bit ext, input string rq);
    clear_mon();
    send_req(op, oth, tgt, adr, ext);
    repeat (6) @(negedge clk);
    chk(n_err == 1, {rq, " error pulse"}, n_err, 1);
    chk(n_wr == 0 && !busy_seen && n_done == 0, {rq, " nothing sent"},
        {n_wr[7:0], 7'h0, busy_seen}, 0);
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    force_pend = 1;
    send_req(2'd2, 1'b0, 32'h3, 32'h8000, 1'b1);
    repeat (30) @(negedge clk);
    send_req(2'd1, 1'b0, 32'h77, 32'h0, 1'b1);
    wait_end();
    force_pend = 0;
    chk(n_err == 0 && n_done == 1, "R10 request while busy ignored (no error, one done)",
        n_err, 0);
    check_boot_words(1'b0, 32'h3, 32'h8000, 1'b1);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_single(2'd0, 1'b0, 32'h5A, 1'b0);          // R9 INIT, R1
    t_single(2'd1, 1'b1, 32'h1234, 1'b0);        // R9 SMI broadcast, R6
    t_single(2'd1, 1'b0, 32'h12345678, 1'b1);    // R8 wide ID accepted, R3
    t_single(2'd0, 1'b1, 32'hABCD, 1'b1);        // R6 broadcast wide
    t_reject(2'd2, 1'b0, 32'h1, 32'h100000, 1'b0, "R7 address at 1 MiB");
    t_reject(2'd2, 1'b0, 32'h1, 32'h9F800, 1'b1, "R7 unaligned address");
    t_reject(2'd0, 1'b0, 32'h100, 32'h0, 1'b0, "R8 ID above 255 in 32-bit style");
    t_reject(2'd3, 1'b0, 32'h1, 32'h0, 1'b1, "R8 reserved operation");
    t_boot(1'b0, 32'h07, 32'h9F000, 1'b0);       // R4 32-bit style
    t_boot(1'b1, 32'h55, 32'h00000, 1'b1);       // R4 R6 wide broadcast
    t_busy_ignore();                             // R10
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule